// File: doc/BRIEF.md
# Speculative Fetch Filter

This block produces instruction fetch addresses for a fetch unit. It also decides whether each address may actually be sent to memory. A demand request or a branch target starts a fetch stream. After each accepted request the block moves one fetch line ahead, and every address reached this way is speculative. A speculative address may not go to memory if the space it lies in is guarded, because a read there could disturb a memory-mapped device. In that case the block holds the address and drops its enable. It waits there until a branch or a demand request redirects it.

Guarding has two sources. With address translation off, a 32-bit region mask covers the 4 GB space in 128 MB slices, and each mask bit protects one slice. With translation on, the translation logic supplies a guard bit for the page that holds the current address. An unconditional branch that sits in decode makes the sequential addresses behind it useless. In that case the block withholds the current sequential request in the same cycle, and on the next cycle it fetches from the branch target.

Top module: `spec_fetch_filter`

## Requirements
- R1: After reset `fetchEn` is 0, `fetchAddr` is 0 and the region mask is all zeros. Until the first branch or demand arrives, `fetchEn` stays 0.
- R2: With `xlateEn`=0, the guard for an address comes from mask bit `rgData[31-k]`, where k = address[31:27]. In this numbering bit 0 is the most significant bit. For example, slice 0x7000_0000..0x77FF_FFFF is k=14, which is `rgData[17]`, and slice 0x7800_0000..0x7FFF_FFFF is k=15, which is `rgData[16]`.
- R3: With `xlateEn`=1, only `pageGuard` decides whether the current address is guarded, and the region mask has no effect.
- R4: When the current address is speculative and guarded, `fetchEn` is 0.
- R5: A demand address or a branch target is non-speculative. It is presented with `fetchEn`=1 even when it is guarded.
- R6: In a cycle with `fetchEn`=1 and `fetchReady`=1, and no branch or demand, the next cycle's `fetchAddr` is the current address aligned down to 16 bytes plus 16. That address is speculative.
- R7: While `brValid`=1, `fetchEn` is 0. In the next cycle `fetchAddr` equals `brTarget`.
- R8: A branch takes priority over a demand request in the same cycle. A demand request takes priority over a sequential advance.
- R9: Sequential prefetch from the last line of one 128 MB slice into a guarded next slice is blocked, because `fetchEn` is 0 at the first address of the next slice.
- R10: A blocked speculative address is held, with `fetchEn`=0, until a branch or a demand request arrives.
- R11: When `rgLoad`=1, `rgData` is written into the region mask. The new mask governs guarding from the next cycle on.
- R12: With `fetchReady`=0 and no branch or demand, `fetchAddr` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| demandValid | input | 1 | Non-speculative demand request |
| demandAddr | input | 32 | Demand fetch address |
| brValid | input | 1 | Unconditional branch in decode |
| brTarget | input | 32 | Branch target address |
| fetchReady | input | 1 | Memory side accepts the request |
| xlateEn | input | 1 | Address translation enabled |
| pageGuard | input | 1 | Guard bit of the page holding `fetchAddr` |
| rgLoad | input | 1 | Write strobe for the region mask |
| rgData | input | 32 | New region mask value |
| fetchAddr | output | 32 | Current fetch address |
| fetchEn | output | 1 | Request `fetchAddr` from memory |

## Verification
The stream is started in three ways: by demand requests, by branch targets, and by a branch and a demand arriving together. Starting each in guarded and unguarded slices separates the non-speculative cases from the speculative ones, and shows which source wins the priority. Sequential runs stepped with and without `fetchReady` show that the line step happens only on accepted requests. A run that starts at the last line of slice 14 and steps into a guarded slice 15 shows that the mask is indexed by the address being fetched. Toggling `xlateEn` against `pageGuard` on a single held address shows which guard source is active.

// File: rtl/sff_pkg.sv
package sff_pkg;
  typedef struct packed {
    logic takeBranch;
    logic takeDemand;
    logic advance;
  } ctrlStrobes_t;
endpackage

// File: rtl/sff_datapath.sv
module sff_datapath
  import sff_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int REGION_BITS = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 st,
  input  logic [ADDR_W-1:0]            brTarget,
  input  logic [ADDR_W-1:0]            demandAddr,
  input  logic                         rgLoad,
  input  logic [(1<<REGION_BITS)-1:0]  rgData,
  output logic [ADDR_W-1:0]            fetchAddr,
  output logic                         regionGuarded
);
  localparam int LINE_LSB    = $clog2(LINE_BYTES);
  localparam int NUM_REGIONS = 1 << REGION_BITS;

  logic [ADDR_W-1:0]      addrQ;
  logic [NUM_REGIONS-1:0] rgQ;
  logic [ADDR_W-1:0]      nextLine;
  logic [REGION_BITS-1:0] regionIdx;
  logic [REGION_BITS-1:0] maskBit;

  assign nextLine  = {addrQ[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}} + ADDR_W'(LINE_BYTES);
  assign regionIdx = addrQ[ADDR_W-1 -: REGION_BITS];
  // region k lives at mask position NUM_REGIONS-1-k (bit 0 is the MSB)
  assign maskBit   = ~regionIdx;
  assign regionGuarded = rgQ[maskBit];
  assign fetchAddr = addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (st.takeBranch) begin
      addrQ <= brTarget;
    end else if (st.takeDemand) begin
      addrQ <= demandAddr;
    end else if (st.advance) begin
      addrQ <= nextLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rgQ <= '0;
    else if (rgLoad) rgQ <= rgData;
  end

  // R7
  redirect_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.takeBranch |=> addrQ == $past(brTarget));
  // R6
  advance_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && !st.takeBranch && !st.takeDemand) |=> addrQ == $past(nextLine));
  // R11
  rg_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    rgLoad |=> rgQ == $past(rgData));
  // R10
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.takeBranch && !st.takeDemand && !st.advance) |=> $stable(addrQ));
endmodule

// File: rtl/sff_ctrl.sv
module sff_ctrl
  import sff_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         brValid,
  input  logic         demandValid,
  input  logic         fetchReady,
  input  logic         xlateEn,
  input  logic         pageGuard,
  input  logic         regionGuarded,
  output ctrlStrobes_t st,
  output logic         fetchEn
);
  logic runQ;
  logic specQ;
  logic guarded;

  assign guarded = xlateEn ? pageGuard : regionGuarded;
  assign fetchEn = runQ & ~brValid & ~(specQ & guarded);

  always_comb begin
    st.takeBranch = brValid;
    st.takeDemand = demandValid & ~brValid;
    st.advance    = fetchEn & fetchReady & ~demandValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      specQ <= 1'b0;
    end else begin
      if (brValid || demandValid) begin
        runQ  <= 1'b1;
        specQ <= 1'b0;
      end else if (st.advance) begin
        specQ <= 1'b1;
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !fetchEn);
  // R5
  redirect_nonspec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brValid || demandValid) |=> !specQ);
  // R4
  guard_veto_chk: assert property (@(posedge clk) disable iff (!rstN)
    (specQ && guarded) |-> !st.advance);
endmodule

// File: rtl/spec_fetch_filter.sv
module spec_fetch_filter
  import sff_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int REGION_BITS = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         demandValid,
  input  logic [ADDR_W-1:0]            demandAddr,
  input  logic                         brValid,
  input  logic [ADDR_W-1:0]            brTarget,
  input  logic                         fetchReady,
  input  logic                         xlateEn,
  input  logic                         pageGuard,
  input  logic                         rgLoad,
  input  logic [(1<<REGION_BITS)-1:0]  rgData,
  output logic [ADDR_W-1:0]            fetchAddr,
  output logic                         fetchEn
);
  ctrlStrobes_t st;
  logic         regionGuarded;

  sff_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .brValid       (brValid),
    .demandValid   (demandValid),
    .fetchReady    (fetchReady),
    .xlateEn       (xlateEn),
    .pageGuard     (pageGuard),
    .regionGuarded (regionGuarded),
    .st            (st),
    .fetchEn       (fetchEn)
  );

  sff_datapath #(
    .ADDR_W      (ADDR_W),
    .LINE_BYTES  (LINE_BYTES),
    .REGION_BITS (REGION_BITS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .st            (st),
    .brTarget      (brTarget),
    .demandAddr    (demandAddr),
    .rgLoad        (rgLoad),
    .rgData        (rgData),
    .fetchAddr     (fetchAddr),
    .regionGuarded (regionGuarded)
  );
endmodule

// File: tb/sim_spec_fetch_filter.sv
module sim_spec_fetch_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        demandValid = 1'b0;
  logic [31:0] demandAddr = '0;
  logic        brValid = 1'b0;
  logic [31:0] brTarget = '0;
  logic        fetchReady = 1'b0;
  logic        xlateEn = 1'b0;
  logic        pageGuard = 1'b0;
  logic        rgLoad = 1'b0;
  logic [31:0] rgData = '0;
  logic [31:0] fetchAddr;
  logic        fetchEn;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [31:0] qAddr[$];
  logic        qEn[$];
  string       qTag[$];

  always #10 clk = ~clk;

  spec_fetch_filter u0 (
    .clk(clk), .rstN(rstN), .demandValid(demandValid), .demandAddr(demandAddr),
    .brValid(brValid), .brTarget(brTarget), .fetchReady(fetchReady),
    .xlateEn(xlateEn), .pageGuard(pageGuard), .rgLoad(rgLoad), .rgData(rgData),
    .fetchAddr(fetchAddr), .fetchEn(fetchEn)
  );

  // driver: apply one cycle of stimulus and queue the expected output
  task automatic drv(input logic br, input logic [31:0] brT, input logic dem,
                     input logic [31:0] demA, input logic rdy, input logic xl,
                     input logic pg, input logic rgL, input logic [31:0] rgD,
                     input logic [31:0] expA, input logic expEn, input string tag);
    @(negedge clk);
    brValid = br; brTarget = brT; demandValid = dem; demandAddr = demA;
    fetchReady = rdy; xlateEn = xl; pageGuard = pg; rgLoad = rgL; rgData = rgD;
    #2;
    qAddr.push_back(expA); qEn.push_back(expEn); qTag.push_back(tag);
  endtask

  // monitor: compare mid-cycle, after the driver has settled inputs
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (qAddr.size() > 0) begin
        logic [31:0] ea;
        logic        ee;
        string       t;
        ea = qAddr.pop_front(); ee = qEn.pop_front(); t = qTag.pop_front();
        compared++;
        if (fetchAddr !== ea || fetchEn !== ee) begin
          mismatched++;
          $display("FAIL %s: actual addr=%h en=%b expected addr=%h en=%b",
                   t, fetchAddr, fetchEn, ea, ee);
        end
      end
    end
  end

  localparam logic [31:0] G14 = 32'h0002_0000; // mask bit 14 -> rgData[17]
  localparam logic [31:0] G15 = 32'h0001_0000; // mask bit 15 -> rgData[16]

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    drv(0,0, 0,0, 0,0,0, 0,0, 32'h0, 0, "R1 reset");
    drv(0,0, 1,32'h1000_0004, 0,0,0, 0,0, 32'h0, 0, "R1 idle");
    // R5 demand presented, R12 hold without ready
    drv(0,0, 0,0, 0,0,0, 0,0, 32'h1000_0004, 1, "R5 demand");
    drv(0,0, 0,0, 0,0,0, 0,0, 32'h1000_0004, 1, "R12 hold");
    drv(0,0, 0,0, 1,0,0, 0,0, 32'h1000_0004, 1, "R6 accept");
    // R6 aligned step, R1 empty mask guards nothing
    drv(0,0, 0,0, 1,0,0, 0,0, 32'h1000_0010, 1, "R6 step");
    // R7 branch in decode kills current sequential request
    drv(1,32'h2000_0100, 0,0, 1,0,0, 0,0, 32'h1000_0020, 0, "R7 gate");
    drv(0,0, 0,0, 0,0,0, 0,0, 32'h2000_0100, 1, "R7 target");
    // R11 load mask guarding slices 14 and 15
    drv(0,0, 0,0, 0,0,0, 1,G14|G15, 32'h2000_0100, 1, "R11 load");
    drv(0,0, 1,32'h7000_0000, 0,0,0, 0,0, 32'h2000_0100, 1, "R8 demand");
    // R5 demand into guarded slice is allowed
    drv(0,0, 0,0, 1,0,0, 0,0, 32'h7000_0000, 1, "R5 guarded demand");
    // R2 R4 speculative into guarded slice 14 blocked
    drv(0,0, 0,0, 1,0,0, 0,0, 32'h7000_0010, 0, "R2 R4 blocked");
    drv(0,0, 0,0, 1,0,0, 0,0, 32'h7000_0010, 0, "R10 held");
    // R3 translated mode uses page guard only
    drv(0,0, 0,0, 0,1,0, 0,0, 32'h7000_0010, 1, "R3 page clear");
    drv(0,0, 0,0, 0,1,1, 0,0, 32'h7000_0010, 0, "R3 page set");
    // R11 drop slice 14 from the mask, effect next cycle
    drv(0,0, 0,0, 0,0,0, 1,G15, 32'h7000_0010, 0, "R11 before");
    drv(0,0, 0,0, 0,0,0, 0,0, 32'h7000_0010, 1, "R11 after");
    // R9 run off the top of slice 14 into guarded slice 15
    drv(0,0, 1,32'h77FF_FFF0, 0,0,0, 0,0, 32'h7000_0010, 1, "R9 setup");
    drv(0,0, 0,0, 1,0,0, 0,0, 32'h77FF_FFF0, 1, "R9 last line");
    drv(0,0, 0,0, 1,0,0, 0,0, 32'h7800_0000, 0, "R9 cross blocked");
    // R8 branch beats demand in same cycle
    drv(1,32'h7800_0040, 1,32'h1234_0000, 1,0,0, 0,0, 32'h7800_0000, 0, "R7 gate2");
    drv(0,0, 0,0, 0,0,0, 0,0, 32'h7800_0040, 1, "R8 branch wins");
    drv(0,0, 0,0, 1,0,0, 0,0, 32'h7800_0040, 1, "R5 target guarded");
    drv(0,0, 0,0, 1,0,0, 0,0, 32'h7800_0050, 0, "R4 spec guarded");
    // R10 demand releases the blocked state
    drv(0,0, 1,32'h1234_0008, 0,0,0, 0,0, 32'h7800_0050, 0, "R10 still held");
    drv(0,0, 0,0, 1,0,0, 0,0, 32'h1234_0008, 1, "R10 released");
    drv(0,0, 0,0, 0,0,0, 0,0, 32'h1234_0010, 1, "R6 align");
    // R8 demand beats sequential advance
    drv(0,0, 1,32'h5000_0000, 1,0,0, 0,0, 32'h1234_0010, 1, "R8 demand vs step");
    drv(0,0, 0,0, 0,0,0, 0,0, 32'h5000_0000, 1, "R8 demand wins");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule